// File: doc/BRIEF.md
# Indirect Host Register File with Command Sequencer

This block is the byte-wide register window that a host processor uses to control a bus-controller chip. The host sees only two locations. Writing the address location sets a 5-bit pointer into a 32-entry register space. Any access to the data location reads or writes the entry under that pointer, and the pointer then moves to the next entry. Long register blocks can therefore be walked with one pointer load. An auxiliary status byte can be read from the address location at any time, without moving the pointer.

Inside the window the block holds general setup bytes, a 24-bit transfer count split over three byte slots, a status byte whose read acknowledges the interrupt, and a command slot. Writing the command slot starts a reset or a target-select sequence. The sequence runs for a fixed number of cycles with the command-in-progress and busy flags set. At the end it posts a status code and raises the interrupt flag. Bus phases and data movement are outside this block. A per-target acknowledge vector stands in for the targets and tells the sequencer whether a selected target answers.

Top module: `hostreg_ctl`

## Requirements
- R1: A write on the address port (port_sel=0) loads the pointer with wdata[4:0] and ignores wdata[7:5]. A read of the address port returns the auxiliary status byte.
- R2: Every data-port access (port_sel=1 with rd or wr) advances the pointer by one on that clock edge. The pointer wraps from 0x1F to 0x00. Address-port accesses do not advance it.
- R3: Data writes at pointer values 0x00–0x16 are stored and read back unchanged. Data writes at 0x17 and at 0x19–0x1F change nothing.
- R4: The 24-bit transfer count sits in three slots: 0x12 holds bits 23:16, 0x13 holds bits 15:8 and 0x14 holds bits 7:0. Writing one slot leaves the other two unchanged.
- R5: After reset, 0x00–0x1A read 0x00, 0x1B–0x1E read 0xFF, and the auxiliary status reads 0x80.
- R6: Auxiliary status layout: bit 7 is the interrupt flag, bit 5 busy and bit 4 command-in-progress. Bits 6 and 0 are defined but always read 0. An accepted reset (0x00) or select (0x06, 0x07) command makes the byte read 0x30 for exactly CMD_LAT cycles. Afterwards it reads 0x80.
- R7: A command write while command-in-progress is set is ignored: the command slot, the status and the sequence in progress are not changed.
- R8: When the reset command completes, 0x01–0x1A are cleared. The status then becomes 0x01 if bit 3 of slot 0x00 is set, and 0x00 otherwise. Slot 0x00 keeps its value.
- R9: A select command latches the target number from bits 2:0 of slot 0x15 when it is accepted. When it completes, the status becomes 0x16 if tgt_ack[target] is 1, and 0x42 if it is 0.
- R10: A data read of slot 0x17 returns the status. If the status is not 0x16, the read clears the interrupt flag. If it is 0x16, the read loads 0x85 into the status and sets the interrupt flag.
- R11: Slot 0x18 reads back the last accepted command code. Codes other than 0x00, 0x06 and 0x07 are stored there and have no other effect.
- R12: rdata is combinational from port_sel, the pointer and the state, whether or not a strobe is active. Side effects take place on the clock edge. If rd and wr are both high on the data port, the access is a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs | input | 1 | Chip select qualifying rd and wr |
| port_sel | input | 1 | 0 selects the address port, 1 the data port |
| rd | input | 1 | Read strobe, one access per cycle it is high |
| wr | input | 1 | Write strobe, one access per cycle it is high |
| wdata | input | 8 | Host write data |
| tgt_ack | input | 2**TGT_BITS | Stub: bit n high means target n answers selection |
| rdata | output | 8 | Host read data |

## Verification
The hardest state to reach is the status value 0x16. From the ports it appears only after a select whose target is acknowledged. Only then can the read that swaps it for 0x85 and raises the interrupt again be exercised, followed by the second read that finally clears it. The stimulus builds this chain explicitly. It programs slot 0x15, drives an acknowledge vector with exactly that target bit set, and polls the auxiliary byte through the command window. During the same window it issues a competing command write to show the lockout. A select to an unanswered target, with the acknowledge bit set for a different target, covers the timeout branch.

// File: rtl/hostreg_pkg.sv
package hostreg_pkg;

  localparam int PTR_W = 5;
  localparam int NSLOT = 1 << PTR_W;

  // slot addresses
  localparam logic [PTR_W-1:0] A_OWNID     = 5'h00;
  localparam logic [PTR_W-1:0] A_TC_HI     = 5'h12;
  localparam logic [PTR_W-1:0] A_TC_MID    = 5'h13;
  localparam logic [PTR_W-1:0] A_TC_LO     = 5'h14;
  localparam logic [PTR_W-1:0] A_DSTID     = 5'h15;
  localparam logic [PTR_W-1:0] A_STORE_TOP = 5'h16;
  localparam logic [PTR_W-1:0] A_STATUS    = 5'h17;
  localparam logic [PTR_W-1:0] A_CMD       = 5'h18;
  localparam logic [PTR_W-1:0] A_ZERO_TOP  = 5'h1A;
  localparam logic [PTR_W-1:0] A_AUX       = 5'h1F;

  // command codes
  localparam logic [7:0] CMD_RESET   = 8'h00;
  localparam logic [7:0] CMD_SEL_ATN = 8'h06;
  localparam logic [7:0] CMD_SEL     = 8'h07;

  // status codes
  localparam logic [7:0] ST_RST     = 8'h00;
  localparam logic [7:0] ST_RST_ADV = 8'h01;
  localparam logic [7:0] ST_XEND    = 8'h16;
  localparam logic [7:0] ST_SELTO   = 8'h42;
  localparam logic [7:0] ST_DISC    = 8'h85;

  // aux status bit positions
  localparam int AUXB_DBR = 0;
  localparam int AUXB_CIP = 4;
  localparam int AUXB_BSY = 5;
  localparam int AUXB_LCI = 6;
  localparam int AUXB_INT = 7;

  localparam int OWN_ADV_BIT = 3;

  typedef enum logic {ENG_IDLE, ENG_RUN} eng_state_e;

endpackage

// File: rtl/hr_ptr.sv
module hr_ptr
  import hostreg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [PTR_W-1:0] load_val,
  input  logic             step_en,
  output logic [PTR_W-1:0] ptr
);
  logic [PTR_W-1:0] ptr_q, ptr_n;

  always_comb begin
    ptr_n = ptr_q;
    if (load_en)      ptr_n = load_val;
    else if (step_en) ptr_n = ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_n;
  end

  assign ptr = ptr_q;

  p_ptr_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> ptr_q == $past(load_val));

  p_ptr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !load_en) |=> ptr_q == $past(ptr_q) + 1'b1);

endmodule

// File: rtl/hr_xfer_cnt.sv
module hr_xfer_cnt #(
  parameter int NBYTES = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NBYTES-1:0]   byte_we,
  input  logic [7:0]          wdata,
  input  logic                clr,
  output logic [8*NBYTES-1:0] count
);
  localparam int CW = 8 * NBYTES;
  logic [CW-1:0] cnt_q, cnt_n;

  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    always_comb begin
      cnt_n[8*g +: 8] = cnt_q[8*g +: 8];
      if (clr)             cnt_n[8*g +: 8] = 8'h00;
      else if (byte_we[g]) cnt_n[8*g +: 8] = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign count = cnt_q;

  p_top_isolated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_we[NBYTES-1] && !clr) |=> $stable(cnt_q[CW-9:0]));

  p_low_isolated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_we[0] && !clr) |=> $stable(cnt_q[CW-1:8]));

endmodule

// File: rtl/hr_cmd_eng.sv
module hr_cmd_eng
  import hostreg_pkg::*;
#(
  parameter int CMD_LAT  = 4,
  parameter int TGT_BITS = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_we,
  input  logic [7:0]               wdata,
  input  logic                     stat_rd,
  input  logic [TGT_BITS-1:0]      dst_id,
  input  logic                     own_adv,
  input  logic [(1<<TGT_BITS)-1:0] tgt_ack,
  output logic [7:0]               aux,
  output logic [7:0]               status,
  output logic [7:0]               cmd_code,
  output logic                     clr_regs
);
  localparam int CNT_W = (CMD_LAT > 1) ? $clog2(CMD_LAT) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(CMD_LAT - 1);

  eng_state_e          state_q, state_n;
  logic [CNT_W-1:0]    cnt_q, cnt_n;
  logic [7:0]          pend_q, pend_n;
  logic [TGT_BITS-1:0] tgt_q, tgt_n;
  logic [7:0]          stat_q, stat_n;
  logic [7:0]          code_q, code_n;
  logic                int_q, int_n;
  logic                accept, runs, done, cip;

  assign cip    = (state_q == ENG_RUN);
  assign accept = cmd_we && !cip;
  assign runs   = (wdata == CMD_RESET) || (wdata == CMD_SEL_ATN) || (wdata == CMD_SEL);
  assign done   = cip && (cnt_q == '0);

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    pend_n  = pend_q;
    tgt_n   = tgt_q;
    stat_n  = stat_q;
    code_n  = code_q;
    int_n   = int_q;

    if (stat_rd) begin
      if (stat_q == ST_XEND) begin
        stat_n = ST_DISC;
        int_n  = 1'b1;
      end else begin
        int_n  = 1'b0;
      end
    end

    if (accept) begin
      code_n = wdata;
      if (runs) begin
        state_n = ENG_RUN;
        cnt_n   = CNT_LOAD;
        pend_n  = wdata;
        tgt_n   = dst_id;
        int_n   = 1'b0;
      end
    end

    if (cip && !done) cnt_n = cnt_q - 1'b1;

    if (done) begin
      state_n = ENG_IDLE;
      int_n   = 1'b1;
      if (pend_q == CMD_RESET) begin
        stat_n = own_adv ? ST_RST_ADV : ST_RST;
        code_n = 8'h00;
      end else begin
        stat_n = tgt_ack[tgt_q] ? ST_XEND : ST_SELTO;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ENG_IDLE;
      cnt_q   <= '0;
      pend_q  <= '0;
      tgt_q   <= '0;
      stat_q  <= '0;
      code_q  <= '0;
      int_q   <= 1'b1;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      pend_q  <= pend_n;
      tgt_q   <= tgt_n;
      stat_q  <= stat_n;
      code_q  <= code_n;
      int_q   <= int_n;
    end
  end

  always_comb begin
    aux           = 8'h00;
    aux[AUXB_INT] = int_q;
    aux[AUXB_BSY] = cip;
    aux[AUXB_CIP] = cip;
    aux[AUXB_LCI] = 1'b0;
    aux[AUXB_DBR] = 1'b0;
  end

  assign status   = stat_q;
  assign cmd_code = code_q;
  assign clr_regs = done && (pend_q == CMD_RESET);

  p_cmd_lockout_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cip) |=> $stable(code_q));

  p_done_raises_int_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cip) |-> int_q);

  p_stat_rd_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !done && stat_q != ST_XEND) |=> !int_q);

  p_stat_rd_disc_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !done && stat_q == ST_XEND) |=> (stat_q == ST_DISC) && int_q);

endmodule

// File: rtl/hostreg_ctl.sv
module hostreg_ctl
  import hostreg_pkg::*;
#(
  parameter int CMD_LAT  = 4,
  parameter int TGT_BITS = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cs,
  input  logic                     port_sel,
  input  logic                     rd,
  input  logic                     wr,
  input  logic [7:0]               wdata,
  input  logic [(1<<TGT_BITS)-1:0] tgt_ack,
  output logic [7:0]               rdata
);
  localparam int TC_BYTES = 3;

  logic [1:0]       rs_q;
  logic             rst_i_n;
  logic [PTR_W-1:0] ptr;
  logic             addr_we, data_acc, dwr, drd;
  logic [7:0]       slot_q [NSLOT];
  logic [TC_BYTES-1:0]   tc_we;
  logic [8*TC_BYTES-1:0] tc;
  logic [7:0]       aux, status, cmd_code;
  logic             clr_regs;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  assign addr_we  = cs && !port_sel && wr;
  assign data_acc = cs && port_sel && (rd || wr);
  assign dwr      = cs && port_sel && wr;
  assign drd      = cs && port_sel && rd && !wr;

  hr_ptr u_ptr (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .load_en  (addr_we),
    .load_val (wdata[PTR_W-1:0]),
    .step_en  (data_acc),
    .ptr      (ptr)
  );

  // general storage slots; transfer-count slots and upper slots hold no flops
  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    if (g <= int'(A_STORE_TOP) && g != int'(A_TC_HI) &&
        g != int'(A_TC_MID) && g != int'(A_TC_LO)) begin : g_reg
      logic [7:0] nxt;
      always_comb begin
        nxt = slot_q[g];
        if (clr_regs && g != int'(A_OWNID))          nxt = 8'h00;
        else if (dwr && ptr == PTR_W'(g))             nxt = wdata;
      end
      always_ff @(posedge clk or negedge rst_i_n) begin
        if (!rst_i_n) slot_q[g] <= 8'h00;
        else          slot_q[g] <= nxt;
      end
    end else begin : g_none
      assign slot_q[g] = 8'h00;
    end
  end

  assign tc_we[2] = dwr && (ptr == A_TC_HI);
  assign tc_we[1] = dwr && (ptr == A_TC_MID);
  assign tc_we[0] = dwr && (ptr == A_TC_LO);

  hr_xfer_cnt #(.NBYTES(TC_BYTES)) u_tc (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .byte_we (tc_we),
    .wdata   (wdata),
    .clr     (clr_regs),
    .count   (tc)
  );

  hr_cmd_eng #(.CMD_LAT(CMD_LAT), .TGT_BITS(TGT_BITS)) u_eng (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .cmd_we   (dwr && (ptr == A_CMD)),
    .wdata    (wdata),
    .stat_rd  (drd && (ptr == A_STATUS)),
    .dst_id   (slot_q[A_DSTID][TGT_BITS-1:0]),
    .own_adv  (slot_q[A_OWNID][OWN_ADV_BIT]),
    .tgt_ack  (tgt_ack),
    .aux      (aux),
    .status   (status),
    .cmd_code (cmd_code),
    .clr_regs (clr_regs)
  );

  always_comb begin
    if (!port_sel) begin
      rdata = aux;
    end else begin
      case (ptr)
        A_TC_HI:  rdata = tc[23:16];
        A_TC_MID: rdata = tc[15:8];
        A_TC_LO:  rdata = tc[7:0];
        A_STATUS: rdata = status;
        A_CMD:    rdata = cmd_code;
        A_AUX:    rdata = aux;
        default: begin
          if (ptr <= A_STORE_TOP)     rdata = slot_q[ptr];
          else if (ptr <= A_ZERO_TOP) rdata = 8'h00;
          else                        rdata = 8'hFF;
        end
      endcase
    end
  end

  p_aux_idle_bits_r6: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!port_sel) |-> (rdata[AUXB_LCI] == 1'b0 && rdata[AUXB_DBR] == 1'b0 &&
                     rdata[AUXB_CIP] == rdata[AUXB_BSY]));

endmodule

// File: tb/hostreg_ctl_bench.sv
module hostreg_ctl_bench;
  localparam int LAT = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 1'b0, port_sel = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] tgt_ack = 8'h00;
  logic [7:0] rdata;

  int vectors = 0;
  int miscompares = 0;

  // reference model state
  int m_slot [32];
  int m_ptr, m_aux, m_busy, m_cnt, m_pend, m_tgt;

  always #2 clk = ~clk;

  hostreg_ctl #(.CMD_LAT(LAT), .TGT_BITS(3)) u_hostreg_ctl (
    .clk(clk), .rst_n(rst_n), .cs(cs), .port_sel(port_sel), .rd(rd), .wr(wr),
    .wdata(wdata), .tgt_ack(tgt_ack), .rdata(rdata)
  );

  task automatic model_reset();
    for (int i = 0; i < 32; i++) m_slot[i] = (i >= 27 && i <= 30) ? 255 : 0;
    m_ptr = 0; m_aux = 8'h80; m_busy = 0; m_cnt = 0; m_pend = 0; m_tgt = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      model_reset();
    end else begin
      bit dw, dr, done;
      int old_cnt, old_busy;
      dw = cs && port_sel && wr;
      dr = cs && port_sel && rd && !wr;
      old_busy = m_busy; old_cnt = m_cnt;
      done = (old_busy != 0) && (old_cnt == 0);
      if (dw) begin
        if (m_ptr <= 22) m_slot[m_ptr] = wdata;
        else if (m_ptr == 24 && old_busy == 0) begin
          m_slot[24] = wdata;
          if (wdata == 0 || wdata == 6 || wdata == 7) begin
            m_busy = 1; m_cnt = LAT - 1; m_pend = wdata;
            m_tgt = m_slot[21] % 8; m_aux = 8'h30;
          end
        end
      end
      if (dr && m_ptr == 23) begin
        if (m_slot[23] == 8'h16) begin m_slot[23] = 8'h85; m_aux = m_aux | 8'h80; end
        else m_aux = m_aux & 8'h7F;
      end
      if (old_busy != 0 && !done) m_cnt = old_cnt - 1;
      if (done) begin
        m_busy = 0; m_aux = 8'h80;
        if (m_pend == 0) begin
          for (int i = 1; i <= 26; i++) m_slot[i] = 0;
          m_slot[23] = ((m_slot[0] & 8) != 0) ? 1 : 0;
        end else begin
          m_slot[23] = tgt_ack[m_tgt] ? 8'h16 : 8'h42;
        end
      end
      if (cs && !port_sel && wr) m_ptr = wdata % 32;
      else if (cs && port_sel && (rd || wr)) m_ptr = (m_ptr + 1) % 32;
    end
  end

  function automatic int m_read();
    if (!port_sel) return m_aux;
    if (m_ptr == 31) return m_aux;
    return m_slot[m_ptr];
  endfunction

  task automatic step(input string tag, input bit ps, input bit r, input bit w,
                      input logic [7:0] d);
    int exp;
    @(negedge clk);
    cs = r | w; port_sel = ps; rd = r; wr = w; wdata = d;
    #1;
    exp = m_read();
    vectors++;
    if (rdata !== exp[7:0]) begin
      miscompares++;
      $display("FAIL %s: ptr=%0h port=%0d rdata=%02h expected %02h",
               tag, m_ptr, ps, rdata, exp[7:0]);
    end
  endtask

  task automatic idle(input string tag, input int n);
    for (int i = 0; i < n; i++) step(tag, 1'b0, 1'b0, 1'b0, 8'h00);
  endtask
  task automatic setp(input string tag, input logic [7:0] a); step(tag, 1'b0, 1'b0, 1'b1, a); endtask
  task automatic wrd (input string tag, input logic [7:0] d); step(tag, 1'b1, 1'b0, 1'b1, d); endtask
  task automatic rdd (input string tag);                      step(tag, 1'b1, 1'b1, 1'b0, 8'h00); endtask
  task automatic poll(input string tag);                      step(tag, 1'b0, 1'b1, 1'b0, 8'h00); endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle("R5", 4);                               // aux reads 0x80 after reset
    setp("R1", 8'h00);
    for (int i = 0; i < 33; i++) rdd("R5");      // full reset map, wraps to 0 (R2)
    // fill storage 0x00..0x16, plus a write to 0x17 that must be dropped (R3)
    setp("R1", 8'h00);
    wrd("R3", 8'h08);
    for (int i = 1; i <= 23; i++) wrd("R3", 8'((i * 7 + 3) & 8'hFF));
    setp("R1", 8'h01);
    for (int i = 1; i <= 24; i++) rdd("R3");
    // transfer count byte isolation
    setp("R4", 8'h13); wrd("R4", 8'hAB);
    setp("R4", 8'h12); rdd("R4"); rdd("R4"); rdd("R4");
    setp("R4", 8'h14); wrd("R4", 8'h5C);
    setp("R4", 8'h12); rdd("R4"); rdd("R4"); rdd("R4");
    // writes to upper slots ignored
    setp("R3", 8'h1D); wrd("R3", 8'h55);
    setp("R3", 8'h19); wrd("R3", 8'h77); wrd("R3", 8'h66);
    setp("R3", 8'h19); for (int i = 0; i < 7; i++) rdd("R3");
    // high pointer bits dropped
    setp("R1", 8'hE5); rdd("R1"); poll("R1");
    // rd and wr together: write wins, pointer steps
    setp("R12", 8'h02); step("R12", 1'b1, 1'b1, 1'b1, 8'h3C); rdd("R12");
    setp("R12", 8'h02); rdd("R12");
    // unsupported command code
    setp("R11", 8'h18); wrd("R11", 8'h44); poll("R11");
    setp("R11", 8'h18); rdd("R11");
    // select to a silent target (target 2, only target 0 answers)
    tgt_ack = 8'b0000_0001;
    setp("R9", 8'h15); wrd("R9", 8'h0A);
    setp("R9", 8'h18); wrd("R6", 8'h06);
    poll("R6");
    setp("R7", 8'h18); wrd("R7", 8'h00);          // ignored while busy
    for (int i = 0; i < 6; i++) poll("R6");
    setp("R7", 8'h17); rdd("R9"); rdd("R7");      // status 0x42, code still 0x06
    poll("R10");
    setp("R10", 8'h17); rdd("R10"); poll("R10");  // second read, interrupt stays clear
    // select to an answering target (target 3)
    tgt_ack = 8'b0000_1000;
    setp("R9", 8'h15); wrd("R9", 8'h03);
    setp("R9", 8'h18); wrd("R6", 8'h07);
    for (int i = 0; i < 7; i++) poll("R6");
    setp("R10", 8'h17); rdd("R9"); poll("R10");   // 0x16, then disconnect with interrupt
    setp("R10", 8'h17); rdd("R10"); poll("R10");  // 0x85, interrupt cleared
    // reset command with bit 3 of slot 0 set
    setp("R8", 8'h18); wrd("R8", 8'h00);
    for (int i = 0; i < 6; i++) poll("R6");
    setp("R8", 8'h00); for (int i = 0; i < 32; i++) rdd("R8");
    // reset command with bit 3 clear
    setp("R8", 8'h00); wrd("R8", 8'hF7);
    setp("R8", 8'h18); wrd("R8", 8'h00);
    for (int i = 0; i < 6; i++) poll("R6");
    setp("R8", 8'h16); rdd("R8"); rdd("R8");
    setp("R8", 8'h00); rdd("R8");
    idle("R12", 3);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule